// File: doc/BRIEF.md
# Instruction Prefetch Queue with Deferred Fetch-Fault Reporting

This block sits between the instruction fetch bus and the decode stage. It issues sequential 16-bit fetches, one at a time, and keeps up to `DEPTH` returned words in a small circular queue. Each stored word carries a fault tag taken from the bus error flag of its response. A failed fetch raises nothing when it returns. The tag travels with the word until decode actually tries to use it.

Decode looks at a window of the oldest `WIN` words. It states how many words the current instruction occupies and asserts a take. If every needed word is present and clean, the words are popped. If any needed word carries a fault tag, the instruction is aborted instead: nothing is popped, and a one-cycle access-error pulse is raised with the fetch address of the first faulted word. A change of program flow (flush) empties the queue in one cycle, restarts fetching at a new address and drops the response of any fetch still outstanding. Fault tags that have not been consumed are lost without a trace.

Top module: `pfq_fault_tag`

## Requirements
- R1: After reset the window shows no valid word, `acc_err_o` is low, and a fetch is requested at address `RESET_PC` (default 0).
- R2: At most one fetch is outstanding. Fetch addresses advance by 2 from the restart address, and requests stop once `DEPTH` words are held, so exactly `DEPTH` grants fill an empty queue.
- R3: Window slot i shows the i-th oldest word, with `dec_vld_o[i]` set when it is present. A take of `dec_len_i` words (1 to 3) whose words are all valid and clean asserts `dec_fire_o` in that cycle and removes exactly that many words.
- R4: A response with `rsp_err_i` set stores its word with the fault tag visible on `dec_flt_o` and raises no access error by itself.
- R5: A flush empties the window by the next cycle and discards all fault tags without any access error, even when a take is asserted in the same cycle.
- R6: A take whose needed words include a faulted one produces `acc_err_o` high for exactly one cycle, the cycle after the take. `acc_err_addr_o` is the fetch address of the first faulted word among the needed ones, which is head address + 2 × slot index.
- R7: An aborted take does not assert `dec_fire_o` and removes no word. The head word is unchanged after the error.
- R8: After an access error, takes are ignored until the next flush. No further pulse and no fire occur.
- R9: A faulted word outside the `dec_len_i` words of the current take has no effect. The take fires normally.
- R10: A fetch outstanding at a flush has its response dropped. No new request is made until that response returns, and the first word after the flush comes from the flush address.
- R11: A take whose needed words are not all valid stalls. It produces no fire and no access error, even if a present word is faulted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Change of program flow |
| flush_pc_i | input | ADDR_W | Restart fetch address for a flush |
| fetch_req_o | output | 1 | Fetch request |
| fetch_addr_o | output | ADDR_W | Address of requested word |
| fetch_gnt_i | input | 1 | Request accepted by the bus |
| rsp_valid_i | input | 1 | Fetch response valid |
| rsp_data_i | input | WORD_W | Returned instruction word |
| rsp_err_i | input | 1 | Bus error on this fetch |
| dec_word_o | output | WIN*WORD_W | Window words, slot 0 = oldest in bits [WORD_W-1:0] |
| dec_vld_o | output | WIN | Slot holds a word |
| dec_flt_o | output | WIN | Slot word is fault-tagged |
| dec_take_i | input | 1 | Decode consumes the current instruction |
| dec_len_i | input | LW | Words in the current instruction (1 to 3) |
| dec_fire_o | output | 1 | Take accepted and words removed |
| acc_err_o | output | 1 | Access-error pulse |
| acc_err_addr_o | output | ADDR_W | Fetch address of the faulted word |

## Verification
The hardest case to reach is a flush that lands while a fetch is in flight. The stale response must then be swallowed rather than enqueued. The bench's bus model has a programmable latency, so a flush can be placed several cycles after a grant and before the response. The bench then checks that the request line stays low and that the refilled head comes from the new address. Fault placement is steered by naming the faulting address before each flush, which puts the tagged word at a chosen slot: the opword, an extension word, or a slot beyond the instruction.

// File: rtl/pfq_fault_tag.sv
module pfq_fault_tag #(
  parameter int DEPTH    = 4,
  parameter int WORD_W   = 16,
  parameter int ADDR_W   = 32,
  parameter int WIN      = 3,
  parameter logic [ADDR_W-1:0] RESET_PC = '0,
  localparam int PW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int LW      = $clog2(WIN + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  flush_i,
  input  logic [ADDR_W-1:0]     flush_pc_i,
  output logic                  fetch_req_o,
  output logic [ADDR_W-1:0]     fetch_addr_o,
  input  logic                  fetch_gnt_i,
  input  logic                  rsp_valid_i,
  input  logic [WORD_W-1:0]     rsp_data_i,
  input  logic                  rsp_err_i,
  output logic [WIN*WORD_W-1:0] dec_word_o,
  output logic [WIN-1:0]        dec_vld_o,
  output logic [WIN-1:0]        dec_flt_o,
  input  logic                  dec_take_i,
  input  logic [LW-1:0]         dec_len_i,
  output logic                  dec_fire_o,
  output logic                  acc_err_o,
  output logic [ADDR_W-1:0]     acc_err_addr_o
);

  logic [WORD_W-1:0] mem_d [DEPTH];
  logic [DEPTH-1:0]  mem_f;
  logic [PW-1:0]     rd_q;
  logic [CW-1:0]     cnt_q;
  logic              busy_q, stale_q, hold_q, err_q;
  logic [ADDR_W-1:0] fpc_q, hpc_q, err_addr_q;

  logic [WIN-1:0] need, bad;
  logic [LW-1:0]  fidx, pop_n;
  logic           use_w, raise, push, gnt_ok;
  logic [PW-1:0]  wr_idx;

  for (genvar g = 0; g < WIN; g++) begin : g_win
    logic [PW-1:0] idx;
    assign idx = rd_q + PW'(g);
    assign dec_word_o[g*WORD_W +: WORD_W] = mem_d[idx];
    assign dec_vld_o[g] = cnt_q > CW'(g);
    assign dec_flt_o[g] = dec_vld_o[g] & mem_f[idx];
    assign need[g]      = dec_len_i > LW'(g);
  end

  assign bad    = need & dec_flt_o;
  assign use_w  = dec_take_i & ~flush_i & ~hold_q & (dec_len_i != '0)
                & (&(~need | dec_vld_o));
  assign raise  = use_w & (|bad);
  assign dec_fire_o = use_w & ~(|bad);
  assign pop_n  = dec_fire_o ? dec_len_i : '0;

  always_comb begin
    fidx = '0;
    for (int i = WIN - 1; i >= 0; i--)
      if (bad[i]) fidx = LW'(i);
  end

  assign fetch_req_o  = ~busy_q & ~flush_i & (cnt_q < CW'(DEPTH));
  assign fetch_addr_o = fpc_q;
  assign gnt_ok       = fetch_req_o & fetch_gnt_i;
  assign push         = rsp_valid_i & busy_q & ~stale_q & ~flush_i;
  assign wr_idx       = rd_q + PW'(cnt_q);

  assign acc_err_o      = err_q;
  assign acc_err_addr_o = err_addr_q;

  always_ff @(posedge clk) begin
    if (push) mem_d[wr_idx] <= rsp_data_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_f      <= '0;
      rd_q       <= '0;
      cnt_q      <= '0;
      busy_q     <= 1'b0;
      stale_q    <= 1'b0;
      hold_q     <= 1'b0;
      err_q      <= 1'b0;
      fpc_q      <= RESET_PC;
      hpc_q      <= RESET_PC;
      err_addr_q <= '0;
    end else begin
      err_q <= raise;
      if (raise) err_addr_q <= hpc_q + (ADDR_W'(fidx) << 1);
      if (flush_i) begin
        cnt_q   <= '0;
        fpc_q   <= flush_pc_i;
        hpc_q   <= flush_pc_i;
        hold_q  <= 1'b0;
        busy_q  <= busy_q & ~rsp_valid_i;
        stale_q <= busy_q & ~rsp_valid_i;
      end else begin
        if (gnt_ok) begin
          busy_q <= 1'b1;
          fpc_q  <= fpc_q + ADDR_W'(2);
        end
        if (rsp_valid_i && busy_q) begin
          busy_q  <= 1'b0;
          stale_q <= 1'b0;
        end
        if (push) mem_f[wr_idx] <= rsp_err_i;
        if (raise) hold_q <= 1'b1;
        rd_q  <= rd_q + PW'(pop_n);
        hpc_q <= hpc_q + (ADDR_W'(pop_n) << 1);
        cnt_q <= cnt_q + CW'(push) - CW'(pop_n);
      end
    end
  end

endmodule

// File: rtl/pfq_fault_tag_chk.sv
module pfq_fault_tag_chk #(
  parameter int WORD_W = 16,
  parameter int WIN    = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  flush_i,
  input logic                  fetch_req_o,
  input logic                  dec_take_i,
  input logic                  dec_fire_o,
  input logic [WIN-1:0]        dec_vld_o,
  input logic [WIN*WORD_W-1:0] dec_word_o,
  input logic                  acc_err_o
);

  p_err_one_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |=> !acc_err_o);

  p_err_from_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(acc_err_o) |-> $past(dec_take_i));

  p_flush_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> !acc_err_o);

  p_flush_empties_r5: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> dec_vld_o == '0);

  p_abort_keeps_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |-> dec_vld_o[0] && $stable(dec_word_o[WORD_W-1:0]));

  p_no_fire_after_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err_o |-> !dec_fire_o);

  p_fire_needs_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dec_fire_o |-> dec_vld_o[0] && dec_take_i);

  p_no_req_in_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |-> !fetch_req_o);

endmodule

bind pfq_fault_tag pfq_fault_tag_chk #(.WORD_W(WORD_W), .WIN(WIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush_i(flush_i), .fetch_req_o(fetch_req_o),
  .dec_take_i(dec_take_i), .dec_fire_o(dec_fire_o), .dec_vld_o(dec_vld_o),
  .dec_word_o(dec_word_o), .acc_err_o(acc_err_o)
);

// File: tb/pfq_fault_tag_tb.sv
`timescale 1ns/1ps
module pfq_fault_tag_tb;
  localparam int AW = 32;
  localparam int WW = 16;

  logic          clk = 0;
  logic          rst_n = 0;
  logic          flush_i = 0;
  logic [AW-1:0] flush_pc_i = '0;
  logic          fetch_req_o;
  logic [AW-1:0] fetch_addr_o;
  logic          fetch_gnt_i = 0;
  logic          rsp_valid_i = 0;
  logic [WW-1:0] rsp_data_i = '0;
  logic          rsp_err_i = 0;
  logic [3*WW-1:0] dec_word_o;
  logic [2:0]    dec_vld_o, dec_flt_o;
  logic          dec_take_i = 0;
  logic [1:0]    dec_len_i = 2'd1;
  logic          dec_fire_o, acc_err_o;
  logic [AW-1:0] acc_err_addr_o;

  pfq_fault_tag u_dut (.*);

  always #5 clk = ~clk;

  int checks = 0, errors = 0, err_seen = 0, gnt_cnt = 0, lat = 1;
  logic [AW-1:0] bad_a = 32'hFFFF_FFF0;

  function automatic logic [WW-1:0] f(input logic [AW-1:0] a);
    return a[15:0] ^ 16'hBEEF;
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // bus model
  initial begin
    logic          pend;
    int            cnt;
    logic [AW-1:0] pa;
    pend = 0; cnt = 0; pa = '0;
    forever begin
      @(negedge clk); #1;
      fetch_gnt_i = 0; rsp_valid_i = 0; rsp_err_i = 0;
      if (pend && cnt == 0) begin
        rsp_valid_i = 1; rsp_data_i = f(pa); rsp_err_i = (pa == bad_a); pend = 0;
      end else if (pend) cnt--;
      else if (fetch_req_o && rst_n) begin
        fetch_gnt_i = 1; pa = fetch_addr_o; pend = 1; cnt = lat; gnt_cnt++;
      end
    end
  end

  always @(negedge clk) if (rst_n && acc_err_o) err_seen++;

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_flush(input logic [AW-1:0] pc, input logic [AW-1:0] bad);
    @(negedge clk);
    bad_a = bad; flush_i = 1; flush_pc_i = pc;
    @(negedge clk);
    flush_i = 0;
    #2 chk("R5 window empty after flush", dec_vld_o, 3'b000);
  endtask

  task automatic take(input logic [1:0] len, input logic exp_fire, input string rq);
    @(negedge clk);
    dec_take_i = 1; dec_len_i = len;
    #2 chk(rq, dec_fire_o, exp_fire);
    @(negedge clk);
    dec_take_i = 0;
    #2;
  endtask

  task automatic t_reset();
    #2;
    chk("R1 no valid after reset", dec_vld_o, 3'b000);
    chk("R1 no error after reset", acc_err_o, 1'b0);
    chk("R1 request after reset", fetch_req_o, 1'b1);
    chk("R1 reset address", fetch_addr_o, 32'h0);
  endtask

  task automatic t_fill();
    tick(40); #2;
    chk("R2 four grants fill queue", gnt_cnt, 4);
    chk("R2 no request when full", fetch_req_o, 1'b0);
    chk("R3 window valid", dec_vld_o, 3'b111);
    chk("R3 slot0", dec_word_o[15:0], f(32'h0));
    chk("R3 slot1", dec_word_o[31:16], f(32'h2));
    chk("R3 slot2", dec_word_o[47:32], f(32'h4));
  endtask

  task automatic t_take();
    take(2'd1, 1'b1, "R3 fire len1");
    chk("R3 head after len1", dec_word_o[15:0], f(32'h2));
    tick(20);
    take(2'd2, 1'b1, "R3 fire len2");
    chk("R3 head after len2", dec_word_o[15:0], f(32'h6));
    tick(20);
    take(2'd3, 1'b1, "R3 fire len3");
    chk("R3 head after len3", dec_word_o[15:0], f(32'hC));
    chk("R3 no errors on clean words", err_seen, 0);
  endtask

  task automatic t_fault_flush();
    do_flush(32'h100, 32'h102);
    tick(40); #2;
    chk("R4 tag on slot1", dec_flt_o, 3'b010);
    chk("R4 no error at fetch", err_seen, 0);
    take(2'd1, 1'b1, "R9 clean opword fires past tag");
    chk("R9 head now faulted word", dec_flt_o[0], 1'b1);
    @(negedge clk);
    flush_i = 1; flush_pc_i = 32'h200; bad_a = 32'hFFFF_FFF0;
    dec_take_i = 1; dec_len_i = 2'd2;
    #2 chk("R5 take with flush no fire", dec_fire_o, 1'b0);
    @(negedge clk);
    flush_i = 0; dec_take_i = 0;
    #2 chk("R5 empty after flush", dec_vld_o, 3'b000);
    chk("R5 no error pulse", acc_err_o, 1'b0);
    tick(40); #2;
    chk("R5 tag discarded", err_seen, 0);
    chk("R5 refill from flush pc", dec_word_o[15:0], f(32'h200));
  endtask

  task automatic t_err_op();
    int base;
    do_flush(32'h300, 32'h300);
    tick(40);
    @(negedge clk);
    dec_take_i = 1; dec_len_i = 2'd1;
    #2 chk("R7 faulted take no fire", dec_fire_o, 1'b0);
    @(negedge clk); #2;
    chk("R6 error pulse", acc_err_o, 1'b1);
    chk("R6 error address opword", acc_err_addr_o, 32'h300);
    chk("R7 head unchanged", dec_word_o[15:0], f(32'h300));
    chk("R7 head still valid", dec_vld_o[0], 1'b1);
    base = err_seen;
    @(negedge clk); #2;
    chk("R6 pulse one cycle", acc_err_o, 1'b0);
    chk("R8 take ignored after error", dec_fire_o, 1'b0);
    tick(5);
    chk("R8 no repeat pulse", err_seen, base);
    dec_take_i = 0;
  endtask

  task automatic t_err_ext();
    do_flush(32'h400, 32'h404);
    tick(40);
    take(2'd2, 1'b1, "R9 fault beyond len ignored");
    chk("R9 no error", err_seen, 1);
    do_flush(32'h500, 32'h504);
    tick(40);
    take(2'd3, 1'b0, "R7 ext fault no fire");
    chk("R6 error on extension word", acc_err_o, 1'b1);
    chk("R6 extension address", acc_err_addr_o, 32'h504);
    chk("R7 nothing popped", dec_word_o[15:0], f(32'h500));
  endtask

  task automatic t_stall();
    lat = 20;
    tick(40);
    do_flush(32'h600, 32'h600);
    take(2'd1, 1'b0, "R11 empty take stalls");
    chk("R11 no error on empty", acc_err_o, 1'b0);
    tick(25); #2;
    chk("R11 one word present", dec_vld_o, 3'b001);
    chk("R11 it is faulted", dec_flt_o, 3'b001);
    take(2'd3, 1'b0, "R11 partial take stalls");
    chk("R11 no error while incomplete", acc_err_o, 1'b0);
    lat = 1;
    tick(60);
  endtask

  task automatic t_drop();
    lat = 8;
    do_flush(32'h700, 32'hFFFF_FFF0);
    tick(2);
    @(negedge clk);
    flush_i = 1; flush_pc_i = 32'h800;
    @(negedge clk);
    flush_i = 0;
    #2 chk("R10 no request while stale fetch pending", fetch_req_o, 1'b0);
    chk("R10 window empty", dec_vld_o, 3'b000);
    tick(80); #2;
    chk("R10 first word from flush pc", dec_word_o[15:0], f(32'h800));
    chk("R10 second word", dec_word_o[31:16], f(32'h802));
    lat = 1;
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    t_reset();
    t_fill();
    t_take();
    t_fault_flush();
    t_err_op();
    t_err_ext();
    t_stall();
    t_drop();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule